// File: doc/BRIEF.md
# Command Ring Consumer

This block drains a circular command ring kept in a word-addressed shared RAM. Software produces commands into the ring and moves a producer pointer forward. The block keeps its own consumer pointer and moves it forward as it takes words out of the ring. Both pointers are byte offsets. The live part of the ring is the window from a lower bound up to, but not including, an upper bound. Four header words at the bottom of the RAM hold the pointers: word 0 is the lower bound, word 1 the upper bound, word 2 the producer pointer and word 3 the consumer pointer.

A config-done pulse makes the block read the four header words and check them. A sync pulse starts a drain. During a drain the block reads the producer pointer and works out how many bytes are waiting. It then decodes whole commands one at a time: screen update, rectangle fill and rectangle copy. Each decoded command goes to a downstream blitter over a valid/ready handshake. After each command the new consumer pointer is written back to header word 3. When a command is only partly present in the ring, the block rewinds to that command's first word and stops until the next sync. When a command code is not recognised, the block halts and raises an error flag.

Top module: `cmdring_consumer`

## Requirements
- R1: On a config-done pulse the block reads header words 0 to 3. It raises cfg_ok_o only if all of the following hold: all four values are multiples of 4; the lower bound is at least 4*HDR_WORDS (16); the upper bound is at most RING_BYTES; the upper bound is at least the lower bound plus MIN_SPAN. Otherwise cfg_ok_o stays low and sync pulses are ignored.
- R2: pending_o equals the producer pointer minus the consumer pointer. When that difference is negative, (upper minus lower) is added to it. pending_o is 0 while enable_i is low or cfg_ok_o is low.
- R3: Each word fetched from the ring comes from byte offset stop (RAM word stop/4). Each fetch advances stop by 4. When the advanced value reaches or passes the upper bound, stop is reloaded with the lower bound.
- R4: Codes 1 and 25 are a screen update with four argument words (x, y, width, height). They are issued with op_kind_o = 0.
- R5: Code 2 is a rectangle fill with five argument words (colour, x, y, width, height). It is issued with op_kind_o = 1.
- R6: Code 3 is a rectangle copy with six argument words (source x, source y, destination x, destination y, width, height). It is issued with op_kind_o = 2. Argument i always sits in op_args_o[32*i+31:32*i], and argument slots that a command does not use read as zero.
- R7: If the pending byte count is smaller than 4 times (1 + argument count), no operation is issued and stop goes back to the command's first word. Busy drops. A later sync with more data consumes the whole command.
- R8: Any other command code, 0 included, sets err_o. Busy drops, stop stays at the offending word and no operation is issued. err_o clears on the next config-done pulse.
- R9: After each handshake the block writes the new stop value to header word 3. This is the only RAM write it makes.
- R10: busy_o rises on the cycle after an accepted sync pulse. It stays high until the ring is empty, a partial command stalls the drain, or an error halts it.
- R11: Once op_valid_o is high, it stays high with unchanged op_kind_o and op_args_o until op_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Block enable; pending count reads zero when low |
| cfg_done_i | input | 1 | Pulse: read and validate the ring header |
| sync_i | input | 1 | Pulse: drain the ring |
| mem_rd_o | output | 1 | RAM read strobe (data returns one cycle later) |
| mem_wr_o | output | 1 | RAM write strobe |
| mem_addr_o | output | AW (14) | RAM word address |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data |
| op_valid_o | output | 1 | Decoded operation valid |
| op_ready_i | input | 1 | Blitter accepts operation |
| op_kind_o | output | 2 | 0 update, 1 fill, 2 copy |
| op_args_o | output | 192 | Six 32-bit argument slots |
| cfg_ok_o | output | 1 | Last header check passed |
| busy_o | output | 1 | Drain in progress |
| err_o | output | 1 | Unknown command seen |
| pending_o | output | 32 | Bytes waiting in the ring |

## Verification
The decode path is tried with all three command shapes and with both update codes. Some runs put several commands in one sync and some hold back the ready signal. These runs separate argument counts, slot order and kind encodings, and show that the payload stays stable while the handshake is held. One command is laid out across the top of the window so that it wraps back to the lower bound; this shows whether the wrap in the pending count and in the pointer step is right. A command is delivered in two parts to exercise the rewind. An illegal code and a disabled block show that nothing is issued and that the stored consumer pointer is left alone. Several malformed headers, each breaking a single rule, show that each validation rule is checked on its own.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int MAX_ARGS = 6;

    typedef enum logic [1:0] {
        OP_UPDATE = 2'd0,
        OP_FILL   = 2'd1,
        OP_COPY   = 2'd2
    } op_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG_REQ,
        S_CFG_DAT,
        S_CFG_CHK,
        S_NXT_REQ,
        S_NXT_DAT,
        S_CMD_REQ,
        S_CMD_DAT,
        S_ARG_REQ,
        S_ARG_DAT,
        S_ISSUE,
        S_WB
    } fsm_e;

    // Step a byte pointer by one word inside [lo, hi).
    function automatic logic [31:0] ring_step(input logic [31:0] p,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        logic [31:0] s;
        s = p + 32'd4;
        return (s >= hi) ? lo : s;
    endfunction

endpackage

// File: rtl/cmdring_cfg_check.sv
module cmdring_cfg_check #(
    parameter int unsigned RING_BYTES = 32'h10000,
    parameter int unsigned MIN_SPAN   = 10240,
    parameter int unsigned HDR_WORDS  = 4
) (
    input  logic [31:0] lo_i,
    input  logic [31:0] hi_i,
    input  logic [31:0] nxt_i,
    input  logic [31:0] stop_i,
    output logic        ok_o
);
    localparam logic [32:0] HDR_BYTES = 33'(HDR_WORDS * 4);
    localparam logic [32:0] RING_LIM  = 33'(RING_BYTES);
    localparam logic [32:0] SPAN      = 33'(MIN_SPAN);

    logic aligned, lo_ok, hi_ok, span_ok;

    always_comb begin
        aligned = ((lo_i | hi_i | nxt_i | stop_i) & 32'd3) == 32'd0;
        lo_ok   = {1'b0, lo_i} >= HDR_BYTES;
        hi_ok   = {1'b0, hi_i} <= RING_LIM;
        span_ok = {1'b0, hi_i} >= ({1'b0, lo_i} + SPAN);
        ok_o    = aligned && lo_ok && hi_ok && span_ok;
    end
endmodule

// File: rtl/cmdring_pending.sv
module cmdring_pending (
    input  logic        en_i,
    input  logic [31:0] lo_i,
    input  logic [31:0] hi_i,
    input  logic [31:0] nxt_i,
    input  logic [31:0] stop_i,
    output logic [31:0] bytes_o
);
    logic [32:0] diff;

    always_comb begin
        diff = {1'b0, nxt_i} - {1'b0, stop_i};
        if (diff[32]) begin
            diff = diff + ({1'b0, hi_i} - {1'b0, lo_i});
        end
        bytes_o = en_i ? diff[31:0] : 32'd0;
    end
endmodule

// File: rtl/cmdring_decode.sv
module cmdring_decode
    import cmdring_pkg::*;
(
    input  logic [31:0] code_i,
    output logic        known_o,
    output op_kind_e    kind_o,
    output logic [2:0]  nargs_o
);
    always_comb begin
        known_o = 1'b1;
        kind_o  = OP_UPDATE;
        nargs_o = 3'd4;
        unique case (code_i)
            32'd1, 32'd25: begin kind_o = OP_UPDATE; nargs_o = 3'd4; end
            32'd2:         begin kind_o = OP_FILL;   nargs_o = 3'd5; end
            32'd3:         begin kind_o = OP_COPY;   nargs_o = 3'd6; end
            default:       begin known_o = 1'b0; nargs_o = 3'd0; end
        endcase
    end
endmodule

// File: rtl/cmdring_consumer.sv
module cmdring_consumer
    import cmdring_pkg::*;
#(
    parameter int unsigned RING_BYTES = 32'h10000,
    parameter int unsigned MIN_SPAN   = 10240,
    parameter int unsigned HDR_WORDS  = 4,
    localparam int AW   = $clog2(RING_BYTES / 4),
    localparam int ARGW = MAX_ARGS * 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable_i,
    input  logic            cfg_done_i,
    input  logic            sync_i,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [31:0]     mem_wdata_o,
    input  logic [31:0]     mem_rdata_i,
    output logic            op_valid_o,
    input  logic            op_ready_i,
    output logic [1:0]      op_kind_o,
    output logic [ARGW-1:0] op_args_o,
    output logic            cfg_ok_o,
    output logic            busy_o,
    output logic            err_o,
    output logic [31:0]     pending_o
);
    // Header word positions that software and this block agree on.
    localparam logic [AW-1:0] W_LO   = AW'(0);
    localparam logic [AW-1:0] W_HI   = AW'(1);
    localparam logic [AW-1:0] W_NXT  = AW'(2);
    localparam logic [AW-1:0] W_STOP = AW'(3);

    typedef struct packed {
        fsm_e                       st;
        logic                       cfg_ok;
        logic                       err;
        logic                       busy;
        logic                       valid;
        logic [31:0]                lo;
        logic [31:0]                hi;
        logic [31:0]                nxt;
        logic [31:0]                stop;
        logic [31:0]                start;
        logic [31:0]                pend;
        logic [1:0]                 cidx;
        logic [2:0]                 nargs;
        logic [2:0]                 aidx;
        op_kind_e                   kind;
        logic [3:0][31:0]           cw;
        logic [MAX_ARGS-1:0][31:0]  args;
    } ctl_t;

    ctl_t r_q, r_d;

    logic        chk_ok;
    logic        dec_known;
    op_kind_e    dec_kind;
    logic [2:0]  dec_nargs;
    logic [31:0] fresh_pend;
    logic [31:0] need_bytes;

    cmdring_cfg_check #(
        .RING_BYTES (RING_BYTES),
        .MIN_SPAN   (MIN_SPAN),
        .HDR_WORDS  (HDR_WORDS)
    ) u_check (
        .lo_i   (r_q.cw[0]),
        .hi_i   (r_q.cw[1]),
        .nxt_i  (r_q.cw[2]),
        .stop_i (r_q.cw[3]),
        .ok_o   (chk_ok)
    );

    cmdring_decode u_dec (
        .code_i  (mem_rdata_i),
        .known_o (dec_known),
        .kind_o  (dec_kind),
        .nargs_o (dec_nargs)
    );

    // Pending bytes seen through the ports (R2).
    cmdring_pending u_pend_out (
        .en_i    (enable_i && r_q.cfg_ok),
        .lo_i    (r_q.lo),
        .hi_i    (r_q.hi),
        .nxt_i   (r_q.nxt),
        .stop_i  (r_q.stop),
        .bytes_o (pending_o)
    );

    // Pending bytes against the producer pointer just read.
    cmdring_pending u_pend_new (
        .en_i    (enable_i && r_q.cfg_ok),
        .lo_i    (r_q.lo),
        .hi_i    (r_q.hi),
        .nxt_i   (mem_rdata_i),
        .stop_i  (r_q.stop),
        .bytes_o (fresh_pend)
    );

    assign need_bytes = {27'd0, dec_nargs + 3'd1, 2'b00};

    always_comb begin
        r_d         = r_q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        unique case (r_q.st)
            S_IDLE: begin
                if (cfg_done_i) begin
                    r_d.st     = S_CFG_REQ;
                    r_d.cidx   = 2'd0;
                    r_d.err    = 1'b0;
                    r_d.cfg_ok = 1'b0;
                end else if (sync_i && r_q.cfg_ok) begin
                    r_d.busy = 1'b1;
                    r_d.st   = S_NXT_REQ;
                end
            end
            S_CFG_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = AW'(r_q.cidx);
                r_d.st     = S_CFG_DAT;
            end
            S_CFG_DAT: begin
                r_d.cw[r_q.cidx] = mem_rdata_i;
                if (r_q.cidx == 2'd3) begin
                    r_d.st = S_CFG_CHK;
                end else begin
                    r_d.cidx = r_q.cidx + 2'd1;
                    r_d.st   = S_CFG_REQ;
                end
            end
            S_CFG_CHK: begin
                r_d.cfg_ok = chk_ok;
                r_d.lo     = r_q.cw[0];
                r_d.hi     = r_q.cw[1];
                r_d.nxt    = r_q.cw[2];
                r_d.stop   = r_q.cw[3];
                r_d.st     = S_IDLE;
            end
            S_NXT_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = W_NXT;
                r_d.st     = S_NXT_DAT;
            end
            S_NXT_DAT: begin
                r_d.nxt  = mem_rdata_i;
                r_d.pend = fresh_pend;
                if (fresh_pend == 32'd0) begin
                    r_d.busy = 1'b0;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.start = r_q.stop;
                    r_d.st    = S_CMD_REQ;
                end
            end
            S_CMD_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = r_q.stop[AW+1:2];
                r_d.stop   = ring_step(r_q.stop, r_q.lo, r_q.hi);
                r_d.st     = S_CMD_DAT;
            end
            S_CMD_DAT: begin
                if (!dec_known) begin
                    // R8: halt on an unrecognised code, keep stop on it
                    r_d.err  = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.stop = r_q.start;
                    r_d.st   = S_IDLE;
                end else if (need_bytes > r_q.pend) begin
                    // R7: command not complete yet, rewind to its first word
                    r_d.busy = 1'b0;
                    r_d.stop = r_q.start;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.kind  = dec_kind;
                    r_d.nargs = dec_nargs;
                    r_d.aidx  = 3'd0;
                    r_d.args  = '0;
                    r_d.st    = S_ARG_REQ;
                end
            end
            S_ARG_REQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = r_q.stop[AW+1:2];
                r_d.stop   = ring_step(r_q.stop, r_q.lo, r_q.hi);
                r_d.st     = S_ARG_DAT;
            end
            S_ARG_DAT: begin
                r_d.args[r_q.aidx] = mem_rdata_i;
                if (r_q.aidx == r_q.nargs - 3'd1) begin
                    r_d.valid = 1'b1;
                    r_d.st    = S_ISSUE;
                end else begin
                    r_d.aidx = r_q.aidx + 3'd1;
                    r_d.st   = S_ARG_REQ;
                end
            end
            S_ISSUE: begin
                if (op_ready_i) begin
                    r_d.valid = 1'b0;
                    r_d.st    = S_WB;
                end
            end
            S_WB: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = W_STOP;
                mem_wdata_o = r_q.stop;
                r_d.st      = S_NXT_REQ;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign op_valid_o = r_q.valid;
    assign op_kind_o  = r_q.kind;
    assign op_args_o  = r_q.args;
    assign cfg_ok_o   = r_q.cfg_ok;
    assign busy_o     = r_q.busy;
    assign err_o      = r_q.err;

    // Header words W_LO and W_HI are only read through cidx during config.
    logic unused_hdr;
    assign unused_hdr = ^{W_LO, W_HI};

endmodule

// File: rtl/cmdring_consumer_chk.sv
module cmdring_consumer_chk #(
    parameter int AW   = 14,
    parameter int ARGW = 192
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable_i,
    input logic            cfg_ok_o,
    input logic            busy_o,
    input logic            err_o,
    input logic            op_valid_o,
    input logic            op_ready_i,
    input logic [1:0]      op_kind_o,
    input logic [ARGW-1:0] op_args_o,
    input logic            mem_rd_o,
    input logic            mem_wr_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic [31:0]     pending_o
);
    p_hold_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_ready_i) |=>
            (op_valid_o && $stable(op_kind_o) && $stable(op_args_o)));

    p_wb_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o == AW'(3) && !mem_rd_o));

    p_pending_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ok_o && enable_i) |-> (pending_o == 32'd0));

    p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

    p_valid_in_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> busy_o);

    p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> (op_kind_o != 2'd3));

    p_handshake_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && op_ready_i) |=> !op_valid_o);
endmodule

bind cmdring_consumer cmdring_consumer_chk #(.AW(AW), .ARGW(ARGW)) u_chk (.*);

// File: tb/cmdring_consumer_tb.sv
module cmdring_consumer_tb;
    localparam int RING  = 16384;
    localparam int SPAN  = 10240;
    localparam int AW    = $clog2(RING / 4);
    localparam int WORDS = RING / 4;
    localparam logic [31:0] LO = 32'd16;
    localparam logic [31:0] HI = 32'd16 + 32'd10240;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable_i = 1'b1;
    logic            cfg_done_i = 1'b0;
    logic            sync_i = 1'b0;
    logic            mem_rd_o, mem_wr_o;
    logic [AW-1:0]   mem_addr_o;
    logic [31:0]     mem_wdata_o;
    logic [31:0]     mem_rdata_i = '0;
    logic            op_valid_o;
    logic            op_ready_i = 1'b0;
    logic [1:0]      op_kind_o;
    logic [191:0]    op_args_o;
    logic            cfg_ok_o, busy_o, err_o;
    logic [31:0]     pending_o;

    logic [31:0] mem [WORDS];
    int          n_chk = 0;
    int          n_err = 0;
    int          hs_cnt = 0;
    int          cyc = 0;
    logic [31:0] wp;

    always #4 clk = ~clk;

    cmdring_consumer #(.RING_BYTES(RING), .MIN_SPAN(SPAN), .HDR_WORDS(4)) u_dut (
        .clk, .rst_n, .enable_i, .cfg_done_i, .sync_i,
        .mem_rd_o, .mem_wr_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
        .op_valid_o, .op_ready_i, .op_kind_o, .op_args_o,
        .cfg_ok_o, .busy_o, .err_o, .pending_o
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (op_valid_o && op_ready_i) hs_cnt <= hs_cnt + 1;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete (actual cycles %0d, expected fewer)", cyc);
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] p, input logic [31:0] lo, input logic [31:0] hi);
        return (p + 32'd4 >= hi) ? lo : p + 32'd4;
    endfunction

    task automatic put(input logic [31:0] w);
        mem[wp[AW+1:2]] = w;
        wp = step(wp, LO, HI);
    endtask

    task automatic header(input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] nx, input logic [31:0] st);
        mem[0] = lo; mem[1] = hi; mem[2] = nx; mem[3] = st;
    endtask

    task automatic do_cfg();
        @(negedge clk) cfg_done_i = 1'b1;
        @(negedge clk) cfg_done_i = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic do_sync(input string req, input bit check_busy);
        @(negedge clk) sync_i = 1'b1;
        @(negedge clk) sync_i = 1'b0;
        if (check_busy) chk(busy_o == 1'b1, req, "busy after sync", 192'(busy_o), 192'd1);
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy_o && t < 500) begin @(negedge clk); t++; end
    endtask

    task automatic expect_op(input string req, input logic [1:0] k,
                             input logic [191:0] a, input int dly);
        int t = 0;
        while (!op_valid_o && t < 300) begin @(negedge clk); t++; end
        chk(op_valid_o == 1'b1, req, "op valid", 192'(op_valid_o), 192'd1);
        chk(op_kind_o == k, req, "op kind", 192'(op_kind_o), 192'(k));
        chk(op_args_o == a, req, "op args", op_args_o, a);
        if (dly > 0) begin
            repeat (dly) @(negedge clk);
            chk(op_valid_o && op_kind_o == k && op_args_o == a, "R11",
                "payload held while stalled", op_args_o, a);
        end
        op_ready_i = 1'b1;
        @(negedge clk) op_ready_i = 1'b0;
        chk(op_valid_o == 1'b0, "R11", "valid drops after handshake", 192'(op_valid_o), 192'd0);
    endtask

    function automatic logic [191:0] args6(input logic [31:0] a0, a1, a2, a3, a4, a5);
        return {a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic t_reset();
        chk(!cfg_ok_o && !busy_o && !err_o && !op_valid_o && pending_o == 0, "R1",
            "reset state", {cfg_ok_o, busy_o, err_o, op_valid_o, pending_o}, 192'd0);
        chk(!mem_wr_o && !mem_rd_o, "R9", "no RAM access at reset", 192'({mem_rd_o, mem_wr_o}), 192'd0);
    endtask

    task automatic t_config();
        header(32'd18, HI, 32'd16, 32'd16); do_cfg();
        chk(!cfg_ok_o, "R1", "misaligned lower bound rejected", 192'(cfg_ok_o), 192'd0);
        header(LO, HI, 32'd16, 32'd18); do_cfg();
        chk(!cfg_ok_o, "R1", "misaligned stop rejected", 192'(cfg_ok_o), 192'd0);
        header(32'd12, 32'd12 + 32'd10240, 32'd16, 32'd16); do_cfg();
        chk(!cfg_ok_o, "R1", "lower bound inside header rejected", 192'(cfg_ok_o), 192'd0);
        header(32'd6144, 32'd16388, 32'd6144, 32'd6144); do_cfg();
        chk(!cfg_ok_o, "R1", "upper bound past ring rejected", 192'(cfg_ok_o), 192'd0);
        header(LO, HI - 32'd4, 32'd16, 32'd16); do_cfg();
        chk(!cfg_ok_o, "R1", "short window rejected", 192'(cfg_ok_o), 192'd0);
        do_sync("R1", 1'b0);
        chk(!busy_o && hs_cnt == 0, "R1", "sync ignored when unconfigured", 192'(busy_o), 192'd0);
        header(LO, HI, 32'd16, 32'd16); do_cfg();
        chk(cfg_ok_o, "R1", "valid header accepted", 192'(cfg_ok_o), 192'd1);
        chk(pending_o == 0, "R2", "empty ring pending", 192'(pending_o), 192'd0);
        wp = 32'd16;
    endtask

    task automatic t_update();
        int h0 = hs_cnt;
        put(1); put(10); put(20); put(30); put(40);
        mem[2] = wp;
        do_sync("R10", 1'b1);
        expect_op("R4", 2'd0, args6(10, 20, 30, 40, 0, 0), 0);
        wait_idle();
        chk(mem[3] == 32'd36, "R9", "stop written back", 192'(mem[3]), 192'd36);
        chk(!busy_o && pending_o == 0, "R10", "idle when empty", 192'(pending_o), 192'd0);
        chk(hs_cnt == h0 + 1, "R4", "one op issued", 192'(hs_cnt - h0), 192'd1);
    endtask

    task automatic t_two_cmds();
        put(25); put(1); put(2); put(3); put(4);
        put(2); put(32'hFF00FF); put(5); put(6); put(7); put(8);
        mem[2] = wp;
        do_sync("R10", 1'b0);
        expect_op("R4", 2'd0, args6(1, 2, 3, 4, 0, 0), 0);
        expect_op("R5", 2'd1, args6(32'hFF00FF, 5, 6, 7, 8, 0), 0);
        wait_idle();
        chk(mem[3] == wp, "R3", "stop after two commands", 192'(mem[3]), 192'(wp));
    endtask

    task automatic t_copy();
        put(3); put(11); put(12); put(13); put(14); put(15); put(16);
        mem[2] = wp;
        do_sync("R6", 1'b0);
        expect_op("R6", 2'd2, args6(11, 12, 13, 14, 15, 16), 5);
        wait_idle();
        chk(mem[3] == wp, "R9", "stop after copy", 192'(mem[3]), 192'(wp));
    endtask

    task automatic t_partial();
        int h0 = hs_cnt;
        logic [31:0] st0 = wp;
        put(2); put(32'hAA); put(5);
        mem[2] = wp;
        do_sync("R7", 1'b0);
        wait_idle();
        chk(hs_cnt == h0 && !op_valid_o, "R7", "no op for partial command", 192'(hs_cnt - h0), 192'd0);
        chk(mem[3] == st0, "R7", "stored stop unchanged", 192'(mem[3]), 192'(st0));
        chk(pending_o == 32'd12, "R7", "pending after rewind", 192'(pending_o), 192'd12);
        put(6); put(7); put(8);
        mem[2] = wp;
        do_sync("R7", 1'b0);
        expect_op("R7", 2'd1, args6(32'hAA, 5, 6, 7, 8, 0), 0);
        wait_idle();
        chk(mem[3] == wp, "R7", "stop after completion", 192'(mem[3]), 192'(wp));
    endtask

    task automatic t_wrap();
        wp = HI - 32'd8;
        put(1); put(100); put(200); put(300); put(400);
        chk(wp == LO + 32'd12, "R3", "bench wrap point", 192'(wp), 192'(LO + 32'd12));
        header(LO, HI, wp, HI - 32'd8); do_cfg();
        chk(pending_o == 32'd20, "R2", "pending across wrap", 192'(pending_o), 192'd20);
        do_sync("R3", 1'b0);
        expect_op("R3", 2'd0, args6(100, 200, 300, 400, 0, 0), 0);
        wait_idle();
        chk(mem[3] == 32'd28, "R3", "stop wrapped to lower bound", 192'(mem[3]), 192'd28);
    endtask

    task automatic t_unknown();
        int h0 = hs_cnt;
        logic [31:0] st0 = wp;
        put(7);
        mem[2] = wp;
        do_sync("R8", 1'b0);
        wait_idle();
        chk(err_o && !busy_o, "R8", "error raised and halted", 192'({err_o, busy_o}), 192'b10);
        chk(hs_cnt == h0, "R8", "no op for unknown code", 192'(hs_cnt - h0), 192'd0);
        chk(mem[3] == st0 && pending_o == 32'd4, "R8", "stop kept at bad word",
            192'(pending_o), 192'd4);
        wp = st0;
        put(1); put(9); put(8); put(7); put(6);
        mem[2] = wp;
        do_cfg();
        chk(!err_o && cfg_ok_o, "R8", "error cleared by config", 192'(err_o), 192'd0);
        do_sync("R8", 1'b0);
        expect_op("R4", 2'd0, args6(9, 8, 7, 6, 0, 0), 0);
        wait_idle();
    endtask

    task automatic t_disabled();
        int h0 = hs_cnt;
        logic [31:0] st0 = wp;
        put(1); put(1); put(1); put(1); put(1);
        mem[2] = wp;
        @(negedge clk) enable_i = 1'b0;
        @(negedge clk);
        chk(pending_o == 0, "R2", "pending zero while disabled", 192'(pending_o), 192'd0);
        do_sync("R2", 1'b0);
        wait_idle();
        chk(hs_cnt == h0 && mem[3] == st0, "R2", "nothing consumed while disabled",
            192'(mem[3]), 192'(st0));
        @(negedge clk) enable_i = 1'b1;
        do_sync("R2", 1'b0);
        expect_op("R4", 2'd0, args6(1, 1, 1, 1, 0, 0), 0);
        wait_idle();
        chk(mem[3] == wp, "R9", "stop after re-enable", 192'(mem[3]), 192'(wp));
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_config();
        t_update();
        t_two_cmds();
        t_copy();
        t_partial();
        t_wrap();
        t_unknown();
        t_disabled();
        finish_run();
    end
endmodule